// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block is a small direct-mapped cache that sits in front of a word-wide backing memory and serves byte reads in an 8-bit address space. It holds four lines of four bytes each. Every line carries a valid flag, a 4-bit tag and a 32-bit data word. A read looks up the indexed line in the same cycle. A hit returns the selected byte at once and does not touch memory. A miss strobes the memory read port with the block address. The memory answers in the same cycle with a whole 32-bit line, and the line is loaded on the next clock edge. The requester holds its read request, and the byte comes back with the hit flag one cycle later.

Byte writes arrive on a separate CPU write port and always go through to memory as a single-lane write. A write to a line that is present also updates that one byte in the cache. A write to a line that is absent leaves the cache unchanged. A read and a write may be presented in the same cycle. When a read miss is filling the same block that is being written, the written byte is merged into the incoming line. Without this merge, the fill would bring in the stale memory word.

Top module: `dm_byte_cache`

## Requirements
- R1: Address fields are tag = addr[7:4], line index = addr[3:2] and byte offset = addr[1:0]. Byte offset k refers to bits [8k+7:8k] of the 32-bit line word, on both the read and the write side.
- R2: After reset every line is invalid, so the first read of any address reports a miss.
- R3: A read hit (indexed line valid, stored tag equal to the address tag) raises cpu_hit, keeps cpu_miss and mem_rd_sel low, and returns the addressed cached byte on cpu_rdata in the same cycle.
- R4: A read miss raises cpu_miss and mem_rd_sel in the same cycle and drives mem_rd_addr with rd_addr[7:2]. The line is filled from mem_rd_data at the next edge, so the same address hits in the following cycle.
- R5: When no read is requested, cpu_hit, cpu_miss and mem_rd_sel are low. cpu_rdata is zero whenever cpu_hit is low.
- R6: Every write request raises mem_wr_en with mem_wr_addr = wr_addr[7:2] and the write byte copied onto all four lanes of mem_wr_data. mem_wr_lane is one-hot, with bit k set for byte offset k.
- R7: A write that hits changes only the addressed byte of the line, from the next cycle on. A read of that byte in the same cycle still returns the old value.
- R8: A write that misses does not allocate. The line at that index keeps its tag and data, and a later read of the written address misses and fetches the updated word from memory.
- R9: When a read miss and a write to the same 4-byte block fall in the same cycle, the filled line holds the written byte in the written lane and memory bytes in the other lanes.
- R10: A read miss replaces the indexed line whatever tag it held before, so a line that has been evicted misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_req | input | 1 | Read request, held until hit |
| rd_addr | input | 8 | Read byte address |
| cpu_rdata | output | 8 | Read byte, zero when no hit |
| cpu_hit | output | 1 | Read hit this cycle |
| cpu_miss | output | 1 | Read miss this cycle |
| wr_req | input | 1 | Byte write request |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| mem_rd_sel | output | 1 | Memory read select, raised only on a read miss |
| mem_rd_addr | output | 6 | Memory block address for the fill |
| mem_rd_data | input | 32 | Line word returned by memory in the same cycle |
| mem_wr_en | output | 1 | Memory byte write enable |
| mem_wr_addr | output | 6 | Memory block address for the write |
| mem_wr_data | output | 32 | Write byte copied on all lanes |
| mem_wr_lane | output | 4 | One-hot byte lane enable |

## Verification
A line fill from a read miss and a byte write can land on the same clock edge. Three cases matter: the write targets the block being fetched, the write hits the line being evicted, or the write hits an unrelated line. The directed part sets up a read miss on one address with a write to a neighbouring byte of the same block in that cycle. It then reads the written byte back and expects the written value rather than the memory word sampled before the write. The random part issues reads and writes in the same cycles over a small tag set, and a bench model of the cache and memory judges every cycle.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  localparam int BYTE_W     = 8;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_IDX_W  = 2;
  localparam int DEF_OFS_W  = 2;
endpackage

// File: rtl/dm_cache_line.sv
// One cache line: valid flag, tag and a word of bytes.
module dm_cache_line
  import dm_cache_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int OFS_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fill_en,
  input  logic [TAG_W-1:0]               fill_tag,
  input  logic [(BYTE_W<<OFS_W)-1:0]     fill_word,
  input  logic                           wr_en,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic [BYTE_W-1:0]              wr_byte,
  output logic                           valid_q,
  output logic [TAG_W-1:0]               tag_q,
  output logic [(BYTE_W<<OFS_W)-1:0]     word_q
);
  localparam int LINE_W = BYTE_W << OFS_W;

  logic              valid_d;
  logic [TAG_W-1:0]  tag_d;
  logic [LINE_W-1:0] word_d;
  logic              upd;

  assign upd = fill_en | wr_en;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    word_d  = word_q;
    if (fill_en) begin
      valid_d = 1'b1;
      tag_d   = fill_tag;
      word_d  = fill_word;
    end else if (wr_en) begin
      word_d[int'(wr_ofs)*BYTE_W +: BYTE_W] = wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (upd) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      tag_q  <= tag_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/dm_byte_pick.sv
// Selects one byte of a line word; zero when not enabled.
module dm_byte_pick
  import dm_cache_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [(BYTE_W<<OFS_W)-1:0] word_i,
  input  logic [OFS_W-1:0]           ofs_i,
  input  logic                       en_i,
  output logic [BYTE_W-1:0]          byte_o
);
  always_comb begin
    byte_o = '0;
    if (en_i) byte_o = word_i[int'(ofs_i)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dm_lane_encode.sv
// Builds the memory-side byte write: lane enable and replicated data.
module dm_lane_encode
  import dm_cache_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic                       en_i,
  input  logic [OFS_W-1:0]           ofs_i,
  input  logic [BYTE_W-1:0]          byte_i,
  output logic [(1<<OFS_W)-1:0]      lane_o,
  output logic [(BYTE_W<<OFS_W)-1:0] word_o
);
  localparam int BYTES = 1 << OFS_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lane_o[b] = en_i && (ofs_i == OFS_W'(b));
    assign word_o[b*BYTE_W +: BYTE_W] = byte_i;
  end
endmodule

// File: rtl/dm_byte_cache.sv
// Direct-mapped byte cache, write-through, no-write-allocate.
module dm_byte_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int IDX_W  = DEF_IDX_W,
  parameter int OFS_W  = DEF_OFS_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [BYTE_W-1:0]           cpu_rdata,
  output logic                        cpu_hit,
  output logic                        cpu_miss,
  input  logic                        wr_req,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic                        mem_rd_sel,
  output logic [ADDR_W-OFS_W-1:0]     mem_rd_addr,
  input  logic [(BYTE_W<<OFS_W)-1:0]  mem_rd_data,
  output logic                        mem_wr_en,
  output logic [ADDR_W-OFS_W-1:0]     mem_wr_addr,
  output logic [(BYTE_W<<OFS_W)-1:0]  mem_wr_data,
  output logic [(1<<OFS_W)-1:0]       mem_wr_lane
);
  localparam int LINES  = 1 << IDX_W;
  localparam int BYTES  = 1 << OFS_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int LINE_W = BYTE_W * BYTES;
  localparam int BLK_W  = ADDR_W - OFS_W;

  // Address fields
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [OFS_W-1:0] rd_ofs, wr_ofs;
  logic [BLK_W-1:0] rd_blk, wr_blk;

  assign rd_tag = rd_addr[ADDR_W-1 -: TAG_W];
  assign wr_tag = wr_addr[ADDR_W-1 -: TAG_W];
  assign rd_idx = rd_addr[OFS_W +: IDX_W];
  assign wr_idx = wr_addr[OFS_W +: IDX_W];
  assign rd_ofs = rd_addr[OFS_W-1:0];
  assign wr_ofs = wr_addr[OFS_W-1:0];
  assign rd_blk = rd_addr[ADDR_W-1:OFS_W];
  assign wr_blk = wr_addr[ADDR_W-1:OFS_W];

  // Line state
  logic              line_vld  [LINES];
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [LINE_W-1:0] line_word [LINES];
  logic [LINES-1:0]  fill_en;
  logic [LINES-1:0]  bwr_en;

  // Lookup
  logic              rd_hit, rd_miss, wr_hit, merge_wr;
  logic [LINE_W-1:0] sel_word, fill_word;

  assign rd_hit   = rd_req && line_vld[rd_idx] && (line_tag[rd_idx] == rd_tag);
  assign rd_miss  = rd_req && !rd_hit;
  assign wr_hit   = wr_req && line_vld[wr_idx] && (line_tag[wr_idx] == wr_tag);
  assign merge_wr = wr_req && rd_miss && (wr_blk == rd_blk);
  assign sel_word = line_word[rd_idx];

  // Fill word: memory line with a same-cycle write to this block merged in
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign fill_word[b*BYTE_W +: BYTE_W] =
      (merge_wr && (wr_ofs == OFS_W'(b))) ? wr_data : mem_rd_data[b*BYTE_W +: BYTE_W];
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign fill_en[i] = rd_miss && (rd_idx == IDX_W'(i));
    assign bwr_en[i]  = wr_hit && (wr_idx == IDX_W'(i)) && !fill_en[i];

    dm_cache_line #(
      .TAG_W (TAG_W),
      .OFS_W (OFS_W)
    ) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_en[i]),
      .fill_tag  (rd_tag),
      .fill_word (fill_word),
      .wr_en     (bwr_en[i]),
      .wr_ofs    (wr_ofs),
      .wr_byte   (wr_data),
      .valid_q   (line_vld[i]),
      .tag_q     (line_tag[i]),
      .word_q    (line_word[i])
    );
  end

  dm_byte_pick #(.OFS_W(OFS_W)) u_pick (
    .word_i (sel_word),
    .ofs_i  (rd_ofs),
    .en_i   (rd_hit),
    .byte_o (cpu_rdata)
  );

  dm_lane_encode #(.OFS_W(OFS_W)) u_lane (
    .en_i   (wr_req),
    .ofs_i  (wr_ofs),
    .byte_i (wr_data),
    .lane_o (mem_wr_lane),
    .word_o (mem_wr_data)
  );

  assign cpu_hit     = rd_hit;
  assign cpu_miss    = rd_miss;
  assign mem_rd_sel  = rd_miss;
  assign mem_rd_addr = rd_blk;
  assign mem_wr_en   = wr_req;
  assign mem_wr_addr = wr_blk;
endmodule

// File: rtl/dm_byte_cache_chk.sv
module dm_byte_cache_chk
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OFS_W  = DEF_OFS_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_req,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic                   wr_req,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [BYTE_W-1:0]      wr_data,
  input logic                   cpu_hit,
  input logic                   cpu_miss,
  input logic [BYTE_W-1:0]      cpu_rdata,
  input logic                   mem_rd_sel,
  input logic                   mem_wr_en,
  input logic [(1<<OFS_W)-1:0]  mem_wr_lane
);
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (!mem_rd_sel && !cpu_miss)); // R3

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mem_rd_sel) && rd_req && (rd_addr == $past(rd_addr))) |-> cpu_hit); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> (!cpu_hit && !cpu_miss && !mem_rd_sel && (cpu_rdata == '0))); // R5

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wr_lane) == 1)); // R6

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_req) && rd_req && cpu_hit && (rd_addr == $past(wr_addr)))
      |-> (cpu_rdata == $past(wr_data))); // R9
endmodule

bind dm_byte_cache dm_byte_cache_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .wr_req      (wr_req),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cpu_hit     (cpu_hit),
  .cpu_miss    (cpu_miss),
  .cpu_rdata   (cpu_rdata),
  .mem_rd_sel  (mem_rd_sel),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_lane (mem_wr_lane)
);

// File: tb/test_dm_byte_cache.sv
module test_dm_byte_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, wr_req;
  logic [7:0]  rd_addr, wr_addr, wr_data;
  logic [7:0]  cpu_rdata;
  logic        cpu_hit, cpu_miss;
  logic        mem_rd_sel, mem_wr_en;
  logic [5:0]  mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic [3:0]  mem_wr_lane;

  logic [31:0] mem  [64];
  logic        rv   [4];
  logic [3:0]  rt   [4];
  logic [31:0] rdat [4];

  int n_chk = 0, n_bad = 0;
  int dut_hits = 0, dut_miss = 0, ref_hits = 0, ref_miss = 0;
  logic       obs_hit, obs_miss;
  logic [7:0] obs_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rd_data = mem[mem_rd_addr];

  dm_byte_cache i_dm_byte_cache (
    .clk (clk), .rst_n (rst_n),
    .rd_req (rd_req), .rd_addr (rd_addr), .cpu_rdata (cpu_rdata),
    .cpu_hit (cpu_hit), .cpu_miss (cpu_miss),
    .wr_req (wr_req), .wr_addr (wr_addr), .wr_data (wr_data),
    .mem_rd_sel (mem_rd_sel), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
    .mem_wr_en (mem_wr_en), .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
    .mem_wr_lane (mem_wr_lane)
  );

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs against the model, update model after the edge.
  task automatic cyc(input bit r, input logic [7:0] ra, input bit w, input logic [7:0] wa, input logic [7:0] wd);
    logic [1:0]  ri, wi;
    bit          eh, em, whit;
    logic [7:0]  er;
    logic [31:0] fw;
    string       tg;
    rd_req = r; rd_addr = ra; wr_req = w; wr_addr = wa; wr_data = wd;
    #1;
    ri = ra[3:2]; wi = wa[3:2];
    eh = r && rv[ri] && (rt[ri] == ra[7:4]);
    em = r && !eh;
    er = eh ? rdat[ri][int'(ra[1:0])*8 +: 8] : 8'h00;
    tg = !r ? "R5" : (eh ? "R3" : "R4");
    obs_hit = cpu_hit; obs_miss = cpu_miss; obs_data = cpu_rdata;
    chk(cpu_hit == eh, tg, 32'(cpu_hit), 32'(eh));
    chk(cpu_miss == em, tg, 32'(cpu_miss), 32'(em));
    chk(cpu_rdata == er, tg, 32'(cpu_rdata), 32'(er));
    chk(mem_rd_sel == em, tg, 32'(mem_rd_sel), 32'(em));
    if (em) chk(mem_rd_addr == ra[7:2], "R4", 32'(mem_rd_addr), 32'(ra[7:2]));
    chk(mem_wr_en == w, "R6", 32'(mem_wr_en), 32'(w));
    if (w) begin
      chk(mem_wr_lane == (4'b0001 << wa[1:0]), "R6", 32'(mem_wr_lane), 32'(4'b0001 << wa[1:0]));
      chk(mem_wr_data == {4{wd}}, "R6", mem_wr_data, {4{wd}});
      chk(mem_wr_addr == wa[7:2], "R6", 32'(mem_wr_addr), 32'(wa[7:2]));
    end
    if (cpu_hit) dut_hits++;
    if (cpu_miss) dut_miss++;
    if (eh) ref_hits++;
    if (em) ref_miss++;
    whit = w && rv[wi] && (rt[wi] == wa[7:4]) && !(em && (ri == wi));
    @(posedge clk);
    #1;
    if (em) begin
      fw = mem[ra[7:2]];
      if (w && (wa[7:2] == ra[7:2])) fw[int'(wa[1:0])*8 +: 8] = wd;
      rv[ri] = 1'b1; rt[ri] = ra[7:4]; rdat[ri] = fw;
    end
    if (whit) rdat[wi][int'(wa[1:0])*8 +: 8] = wd;
    if (w) mem[wa[7:2]][int'(wa[1:0])*8 +: 8] = wd;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b1, a, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) mem[i][k*8 +: 8] = init_byte(8'(i*4 + k));
    for (int i = 0; i < 4; i++) rv[i] = 1'b0;
    rd_req = 0; wr_req = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_hit == 1'b0 && cpu_miss == 1'b0, "R5", 32'({cpu_hit, cpu_miss}), 32'd0);
    rst_n = 1'b1;

    // R2: first access after reset misses on every line
    for (int i = 0; i < 4; i++) begin
      rd(8'(i*4 + 1));
      chk(obs_miss == 1'b1, "R2", 32'(obs_miss), 32'd1);
    end

    // R1/R4: miss then hit, all four offsets of one line
    rd(8'hB6);
    chk(obs_miss == 1'b1, "R4", 32'(obs_miss), 32'd1);
    for (int k = 0; k < 4; k++) begin
      rd(8'hB4 + 8'(k));
      chk(obs_hit == 1'b1 && obs_data == init_byte(8'hB4 + 8'(k)), "R1",
          32'(obs_data), 32'(init_byte(8'hB4 + 8'(k))));
    end

    // R10: a different tag on the same index evicts the line
    rd(8'h76);
    rd(8'h76);
    rd(8'hB6);
    chk(obs_miss == 1'b1, "R10", 32'(obs_miss), 32'd1);
    rd(8'h76);
    chk(obs_miss == 1'b1, "R10", 32'(obs_miss), 32'd1);

    // R7: write hit; same-cycle read sees old byte, next read sees new
    cyc(1'b1, 8'h75, 1'b1, 8'h75, 8'hC3);
    chk(obs_data == init_byte(8'h75), "R7", 32'(obs_data), 32'(init_byte(8'h75)));
    rd(8'h75);
    chk(obs_hit && obs_data == 8'hC3, "R7", 32'(obs_data), 32'hC3);
    rd(8'h74);
    chk(obs_data == init_byte(8'h74), "R7", 32'(obs_data), 32'(init_byte(8'h74)));

    // R8: write miss leaves the line alone; later read fetches updated memory
    cyc(1'b0, 8'h00, 1'b1, 8'h15, 8'h9E);
    rd(8'h75);
    chk(obs_hit && obs_data == 8'hC3, "R8", 32'(obs_data), 32'hC3);
    rd(8'h15);
    chk(obs_miss == 1'b1, "R8", 32'(obs_miss), 32'd1);
    rd(8'h15);
    chk(obs_hit && obs_data == 8'h9E, "R8", 32'(obs_data), 32'h9E);

    // R9: read miss and write to the same block in one cycle
    cyc(1'b1, 8'hE8, 1'b1, 8'hEA, 8'h3C);
    chk(obs_miss == 1'b1, "R9", 32'(obs_miss), 32'd1);
    rd(8'hEA);
    chk(obs_hit && obs_data == 8'h3C, "R9", 32'(obs_data), 32'h3C);
    rd(8'hE8);
    chk(obs_hit && obs_data == init_byte(8'hE8), "R9", 32'(obs_data), 32'(init_byte(8'hE8)));

    // Random mix of reads and writes over three tags
    for (int n = 0; n < 3000; n++) begin
      bit         r, w;
      logic [7:0] ra, wa;
      r  = ($urandom % 10) < 7;
      w  = ($urandom % 10) < 3;
      ra = {2'b00, 2'($urandom % 3), 2'($urandom), 2'($urandom)};
      wa = {2'b00, 2'($urandom % 3), 2'($urandom), 2'($urandom)};
      if (n % 5 == 0) wa = ra;
      cyc(r, ra, w, wa, 8'($urandom));
    end

    chk(dut_hits == ref_hits, "R3", 32'(dut_hits), 32'(ref_hits));
    chk(dut_miss == ref_miss, "R4", 32'(dut_miss), 32'(ref_miss));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule